// File: doc/BRIEF.md
# Light-Load Mode Switching Controller

This block is the per-channel digital controller of a step-down converter that decides whether the channel runs in fixed-frequency PWM or in pulse-frequency (PFM) operation. While in PFM it also drives the high-side and low-side switch enables directly. The analog front end supplies it with sampled comparator flags: output below the upper PFM threshold, below the wake threshold and below the exit threshold, low-side current at zero, peak current under the mode threshold, and peak current over the PFM limit. A forced-PWM configuration bit lets software keep the channel in PWM at all times.

In PWM the block keeps both of its gate enables low, because the duty modulator outside this block owns the switches. The channel drops into PFM only after a light-load indication has persisted without a break for a programmable number of switching clocks. Inside PFM it cycles through three phases: high side on, low side on, and both off (idle). It returns to PWM at once when the output sags below the exit threshold.

Top module: `lightload_mode_ctrl`

## Requirements
- R1: Under reset, and in the first cycle after reset is released, the channel is in PWM (pfm_mode=0) with hs_en=0 and ls_en=0.
- R2: While in PWM with force_pwm=0, the channel enters PFM on the clock edge at which (ls_zero OR pk_below_mode) has been 1 for QUAL_CYCLES consecutive edges (default 32). It enters the idle phase, in which hs_en=0 and ls_en=0.
- R3: Any edge at which neither ls_zero nor pk_below_mode is 1 restarts the count, so 31 qualifying edges, a gap and 31 more leave the channel in PWM.
- R4: In the idle phase, below_lo=1 starts a burst: the high-side phase follows on the next edge. below_hi=1 alone does not wake the channel.
- R5: The high-side phase lasts while below_hi=1 and pk_above_lim=0. On the edge at which either condition fails, the channel moves to the low-side phase.
- R6: The low-side phase holds until ls_zero=1. It then goes to the high-side phase if below_hi=1, and to idle otherwise.
- R7: In any PFM phase, below_lo2=1 returns the channel to PWM on the next edge, ahead of any phase move.
- R8: force_pwm=1 keeps the channel in PWM whatever the qualifying inputs do, and forces a PFM channel back to PWM on the next edge.
- R9: hs_en and ls_en are never 1 in the same cycle, and both are 0 whenever pfm_mode=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_pwm | input | 1 | Configuration bit that holds the channel in PWM |
| below_hi | input | 1 | Output below the upper PFM threshold |
| below_lo | input | 1 | Output below the PFM wake threshold |
| below_lo2 | input | 1 | Output below the PFM exit threshold |
| ls_zero | input | 1 | Low-side switch current has reached zero |
| pk_below_mode | input | 1 | Peak high-side current below the mode threshold |
| pk_above_lim | input | 1 | Peak high-side current above the PFM limit |
| pfm_mode | output | 1 | 1 in PFM, 0 in PWM |
| hs_en | output | 1 | High-side gate enable in PFM |
| ls_en | output | 1 | Low-side gate enable in PFM |

## Verification
The burst sequencer is walked through a table that ends the high-side phase once by the peak-current limit and once by crossing the upper threshold. The table also leaves the low-side phase toward both the high-side phase and idle, which separates the two exits of each phase. Qualification is tried with a broken run of 31 + 31 edges against an unbroken run of 32, using each of the two light-load flags, so that an off-by-one or a counter that is never cleared shows up. Exit is tried through the exit threshold, through force_pwm from the high-side phase, and through reset in the middle of a burst. A wake attempt with only the upper-threshold flag set shows whether the idle phase listens to the correct threshold.

// File: rtl/lightload_mode_pkg.sv
package lightload_mode_pkg;

  typedef enum logic [1:0] {
    PH_PWM  = 2'd0,
    PH_HSON = 2'd1,
    PH_LSON = 2'd2,
    PH_IDLE = 2'd3
  } phase_e;

  // light-load indication used for PWM-to-PFM qualification
  function automatic logic light_load(input logic ls_zero, input logic pk_below_mode);
    return ls_zero | pk_below_mode;
  endfunction

  // high-side phase ends when the output has risen or the current limit tripped
  function automatic logic hs_done(input logic below_hi, input logic pk_above_lim);
    return (!below_hi) | pk_above_lim;
  endfunction

endpackage

// File: rtl/persist_qual.sv
module persist_qual #(
  parameter int QUAL_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cond,
  output logic done
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] run_q;

  assign done = cond && !clear && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (clear || !cond) run_q <= '0;
    else if (run_q != LAST) run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/pfm_sequencer.sv
module pfm_sequencer
  import lightload_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   force_pwm,
  input  logic   below_hi,
  input  logic   below_lo,
  input  logic   below_lo2,
  input  logic   ls_zero,
  input  logic   pk_above_lim,
  input  logic   qual_done,
  output phase_e phase
);
  phase_e phase_d;
  logic   exit_req;

  assign exit_req = force_pwm || below_lo2;

  always_comb begin
    phase_d = phase;
    if (phase == PH_PWM) begin
      if (!force_pwm && qual_done) phase_d = PH_IDLE;
    end else if (exit_req) begin
      phase_d = PH_PWM;
    end else begin
      case (phase)
        PH_HSON: if (hs_done(below_hi, pk_above_lim)) phase_d = PH_LSON;
        PH_LSON: if (ls_zero) phase_d = below_hi ? PH_HSON : PH_IDLE;
        PH_IDLE: if (below_lo) phase_d = PH_HSON;
        default: phase_d = PH_PWM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_PWM;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/gate_decode.sv
module gate_decode
  import lightload_mode_pkg::*;
(
  input  phase_e phase,
  output logic   pfm_mode,
  output logic   hs_en,
  output logic   ls_en
);
  assign pfm_mode = (phase != PH_PWM);
  assign hs_en    = (phase == PH_HSON);
  assign ls_en    = (phase == PH_LSON);
endmodule

// File: rtl/lightload_mode_ctrl.sv
module lightload_mode_ctrl
  import lightload_mode_pkg::*;
#(
  parameter int QUAL_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_pwm,
  input  logic below_hi,
  input  logic below_lo,
  input  logic below_lo2,
  input  logic ls_zero,
  input  logic pk_below_mode,
  input  logic pk_above_lim,
  output logic pfm_mode,
  output logic hs_en,
  output logic ls_en
);
  phase_e phase;
  logic   qual_cond;
  logic   qual_clear;
  logic   qual_done;

  assign qual_cond  = light_load(ls_zero, pk_below_mode);
  assign qual_clear = force_pwm || (phase != PH_PWM);

  persist_qual #(.QUAL_CYCLES(QUAL_CYCLES)) qual_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (qual_clear),
    .cond  (qual_cond),
    .done  (qual_done)
  );

  pfm_sequencer seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .force_pwm    (force_pwm),
    .below_hi     (below_hi),
    .below_lo     (below_lo),
    .below_lo2    (below_lo2),
    .ls_zero      (ls_zero),
    .pk_above_lim (pk_above_lim),
    .qual_done    (qual_done),
    .phase        (phase)
  );

  gate_decode dec_i (
    .phase    (phase),
    .pfm_mode (pfm_mode),
    .hs_en    (hs_en),
    .ls_en    (ls_en)
  );
endmodule

// File: rtl/lightload_mode_ctrl_chk.sv
module lightload_mode_ctrl_chk #(
  parameter int QUAL_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic force_pwm,
  input logic below_lo2,
  input logic ls_zero,
  input logic pk_below_mode,
  input logic pfm_mode,
  input logic hs_en,
  input logic ls_en
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] seen_q;
  logic          full_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (pfm_mode || force_pwm || !(ls_zero || pk_below_mode)) seen_q <= '0;
    else if (seen_q != LAST) seen_q <= seen_q + 1'b1;
  end

  assign full_run = !pfm_mode && !force_pwm && (ls_zero || pk_below_mode) && (seen_q == LAST);

  // R2
  qual_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_run |=> pfm_mode);

  // R3
  qual_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfm_mode && !full_run) |=> !pfm_mode);

  // R5
  hs_to_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_en) && pfm_mode) |-> ls_en);

  // R6
  ls_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en && ls_zero) |=> !ls_en);

  // R7
  lo2_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfm_mode && below_lo2) |=> !pfm_mode);

  // R8
  force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_pwm |=> !pfm_mode);

  // R9
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (!ls_en && pfm_mode));

  // R9
  pwm_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pfm_mode |-> (!hs_en && !ls_en));
endmodule

bind lightload_mode_ctrl lightload_mode_ctrl_chk #(.QUAL_CYCLES(QUAL_CYCLES)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .force_pwm     (force_pwm),
  .below_lo2     (below_lo2),
  .ls_zero       (ls_zero),
  .pk_below_mode (pk_below_mode),
  .pfm_mode      (pfm_mode),
  .hs_en         (hs_en),
  .ls_en         (ls_en)
);

// File: tb/lightload_mode_ctrl_tb_top.sv
module lightload_mode_ctrl_tb_top;
  localparam int QUAL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_pwm = 1'b0, below_hi = 1'b0, below_lo = 1'b0, below_lo2 = 1'b0;
  logic ls_zero = 1'b0, pk_below_mode = 1'b0, pk_above_lim = 1'b0;
  logic pfm_mode, hs_en, ls_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  lightload_mode_ctrl #(.QUAL_CYCLES(QUAL)) dut_i (
    .clk(clk), .rst_n(rst_n), .force_pwm(force_pwm), .below_hi(below_hi),
    .below_lo(below_lo), .below_lo2(below_lo2), .ls_zero(ls_zero),
    .pk_below_mode(pk_below_mode), .pk_above_lim(pk_above_lim),
    .pfm_mode(pfm_mode), .hs_en(hs_en), .ls_en(ls_en)
  );

  // bits: [9]force [8]below_hi [7]below_lo [6]below_lo2 [5]ls_zero [4]pk_below_mode
  //       [3]pk_above_lim [2]exp pfm_mode [1]exp hs_en [0]exp ls_en
  // starts in PFM idle; covers R4, R5, R6, R7
  localparam logic [9:0] VEC [11] = '{
    10'b0110000110,  // idle, below_lo -> high side (R4)
    10'b0100000110,  // still below_hi -> stay high side (R5)
    10'b0100001101,  // limit trip -> low side (R5)
    10'b0100000101,  // no zero current -> hold low side (R6)
    10'b0100100110,  // zero current, below_hi -> high side (R6)
    10'b0000000101,  // above hi -> low side (R5)
    10'b0000100100,  // zero current, above hi -> idle (R6)
    10'b0100000100,  // below_hi alone -> stay idle (R4)
    10'b0110000110,  // wake again (R4)
    10'b0111000000,  // below_lo2 -> PWM (R7)
    10'b0000000000   // stay PWM
  };

  task automatic check(input string req, input logic ep, input logic eh, input logic el);
    n_chk++;
    if (pfm_mode !== ep || hs_en !== eh || ls_en !== el) begin
      n_bad++;
      $display("FAIL %s: got pfm/hs/ls=%b%b%b expected %b%b%b", req,
               pfm_mode, hs_en, ls_en, ep, eh, el);
    end
  endtask

  task automatic drive(input logic f, input logic bh, input logic bl, input logic bl2,
                       input logic lz, input logic pm, input logic pl);
    force_pwm = f; below_hi = bh; below_lo = bl; below_lo2 = bl2;
    ls_zero = lz; pk_below_mode = pm; pk_above_lim = pl;
    @(negedge clk);
  endtask

  task automatic qualify(input int n, input logic use_pm);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, !use_pm, use_pm, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    drive(0, 1, 1, 0, 0, 0, 0);
    check("R1 after release", 0, 0, 0);

    // enter PFM through ls_zero
    qualify(QUAL - 1, 1'b0);
    check("R2 31 edges", 0, 0, 0);
    qualify(1, 1'b0);
    check("R2 32nd edge idle", 1, 0, 0);

    for (int r = 0; r < 11; r++) begin
      logic [9:0] v;
      v = VEC[r];
      drive(v[9], v[8], v[7], v[6], v[5], v[4], v[3]);
      check($sformatf("R5/R6 table row %0d", r), v[2], v[1], v[0]);
      n_chk++;
      if (hs_en && ls_en) begin
        n_bad++;
        $display("FAIL R9 row %0d: got hs=1 ls=1 expected not both", r);
      end
    end

    // broken run restarts count
    qualify(QUAL - 1, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R3 gap", 0, 0, 0);
    qualify(QUAL - 1, 1'b1);
    check("R3 after 31 more", 0, 0, 0);
    qualify(1, 1'b1);
    check("R2 pk_below_mode run", 1, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0);
    check("R4 below_hi no wake", 1, 0, 0);

    // force from high side
    drive(0, 1, 1, 0, 0, 0, 0);
    check("R4 wake high side", 1, 1, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    check("R8 force exit", 0, 0, 0);
    for (int i = 0; i < QUAL + 8; i++) drive(1, 0, 0, 0, 1, 1, 0);
    check("R8 force holds", 0, 0, 0);

    // exit threshold from idle
    qualify(QUAL, 1'b0);
    check("R2 requalify", 1, 0, 0);
    drive(0, 0, 0, 1, 1, 0, 0);
    check("R7 exit from idle", 0, 0, 0);

    // exit threshold beats phase move in low side
    qualify(QUAL, 1'b0);
    drive(0, 1, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R5 to low side", 1, 0, 1);
    drive(0, 1, 0, 1, 1, 0, 0);
    check("R7 priority over low side exit", 0, 0, 0);

    // reset during burst
    qualify(QUAL, 1'b1);
    drive(0, 1, 1, 0, 0, 0, 0);
    check("R4 burst before reset", 1, 1, 0);
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid burst", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 1, 1, 0, 1, 1, 0);
    check("R1 after mid-burst reset", 0, 0, 0);

    finish_run();
  end
endmodule